// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a double-buffered 16-bit digital-to-analog converter that has a parallel bus. A requester hands it one command at a time over a valid/ready handshake. The block then produces the two register-select lines, the data bus, the active-low write strobe and the active-low clear pulse that the converter expects. Four commands exist: write the input register, copy it into the output register, do both in one step, and clear.

Every interval on the bus is produced by counting clock cycles. Each count is derived at elaboration time from a nanosecond minimum and the clock period: it is the ceiling of the minimum divided by the period, and never less than one cycle. The combined command normally becomes two back-to-back write cycles. With the per-command transparent flag set, it becomes a single write with both selects low and a longer strobe. All bus outputs are registered, so they change only on clock edges.

Top module: `dac_write_seq`

## Requirements
- R1: During and after reset, `dacSel` is 2'b11, `dacWrN` and `dacClrN` are 1, `dacData` is zero and `cmdReady` is 1.
- R2: `cmdOp` 0 (load input register) produces exactly one write strobe with `dacSel` = 2'b10 (bit 1 high, bit 0 low) and the command data on `dacData`.
- R3: `cmdOp` 1 (update output register) produces exactly one write strobe with `dacSel` = 2'b01.
- R4: `cmdOp` 2 with `cmdTransparent` = 0 produces two write strobes carrying the same data, the first with `dacSel` = 2'b10 and the second with 2'b01.
- R5: `cmdOp` 2 with `cmdTransparent` = 1 produces a single write strobe with `dacSel` = 2'b00 that stays low for exactly ceil(T_WP_SB_NS / CLK_PERIOD_NS) cycles (10 at the defaults).
- R6: For every other write, `dacWrN` stays low for exactly ceil(T_WP_NS / CLK_PERIOD_NS) cycles (7 at the defaults).
- R7: `dacSel` and `dacData` are unchanged for at least ceil(T_SETUP_NS / CLK_PERIOD_NS) cycles (7) before each rising edge of `dacWrN`, and `dacSel` is never 2'b11 while the strobe is low.
- R8: `dacSel` and `dacData` stay unchanged for at least ceil(T_HOLD_NS / CLK_PERIOD_NS) cycles (2) after each rising edge of `dacWrN`.
- R9: `cmdOp` 3 (clear) drives `dacClrN` low for exactly ceil(T_CLR_NS / CLK_PERIOD_NS) cycles (25). During that time `dacWrN` stays high, `dacSel` stays 2'b11 and `dacData` keeps its previous value.
- R10: `cmdReady` is low from the cycle after a command is accepted until the sequence ends, and no command is taken in that time. `cmdTransparent` has no effect on opcodes 0, 1 and 3.
- R11: When a command has finished, `dacSel` is back to 2'b11 with both strobes high before `cmdReady` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle and taking a command |
| cmdOp | input | 2 | 0 load, 1 update, 2 load and update, 3 clear |
| cmdTransparent | input | 1 | Opcode 2 only: single write with both selects low |
| cmdData | input | DATA_W | Sample for the converter |
| dacSel | output | 2 | Register selects, bit 1 and bit 0 |
| dacData | output | DATA_W | Parallel data bus |
| dacWrN | output | 1 | Write strobe, active low |
| dacClrN | output | 1 | Clear pulse, active low |

## Verification
Two events can meet in one cycle. The first is the end of one write's hold window. The second is the start of the next bus activity: either the second phase of a combined command switching the selects, or a new command that has waited on `cmdValid` and is taken the instant `cmdReady` returns. The bench keeps a second command with different data asserted for the whole of the first one's sequence. It then checks that the bus data never moved while the block was busy, and that the first write still met its full hold count before the second write's setup began. Setup, hold and pulse widths are measured from the waveforms by an independent monitor, not taken from the control state.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_UPDATE = 2'd1,
    OP_BOTH   = 2'd2,
    OP_CLEAR  = 2'd3
  } cmdOp_e;

  // bit 1 and bit 0 of the select pair, as the converter decodes them
  typedef enum logic [1:0] {
    SEL_THROUGH = 2'b00,
    SEL_UPDATE  = 2'b01,
    SEL_LOAD    = 2'b10,
    SEL_IDLE    = 2'b11
  } selCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE,
    ST_CLEAR
  } seqState_e;

  typedef struct packed {
    logic     capture;
    logic     driveSel;
    selCode_e selCode;
    logic     wrLow;
    logic     clrLow;
  } seqStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int SETUP_CYC = 7,
  parameter int WP_CYC    = 7,
  parameter int WP_SB_CYC = 10,
  parameter int HOLD_CYC  = 2,
  parameter int CLR_CYC   = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdTransparent,
  output logic       cmdReady,
  output seqStrobe_t strobe
);

  // the strobe low time counts towards setup, so the pre-strobe phase only covers the rest
  localparam int SETUP_DB = (SETUP_CYC > WP_CYC)    ? SETUP_CYC - WP_CYC    : 1;
  localparam int SETUP_SB = (SETUP_CYC > WP_SB_CYC) ? SETUP_CYC - WP_SB_CYC : 1;
  localparam int MAX_A    = (CLR_CYC > WP_SB_CYC) ? CLR_CYC : WP_SB_CYC;
  localparam int MAX_B    = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SETUP_DB_M1 = CNT_W'(SETUP_DB - 1);
  localparam logic [CNT_W-1:0] SETUP_SB_M1 = CNT_W'(SETUP_SB - 1);
  localparam logic [CNT_W-1:0] WP_M1       = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WP_SB_M1    = CNT_W'(WP_SB_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_M1     = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] CLR_M1      = CNT_W'(CLR_CYC - 1);

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  selCode_e         curSel;
  logic             pendUpdate;
  logic             longPulse;
  logic             accept;
  logic             cntDone;

  assign accept  = (state == ST_IDLE) && cmdValid;
  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      curSel     <= SEL_IDLE;
      pendUpdate <= 1'b0;
      longPulse  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            pendUpdate <= 1'b0;
            longPulse  <= 1'b0;
            case (cmdOp_e'(cmdOp))
              OP_LOAD: begin
                curSel <= SEL_LOAD;
                cnt    <= SETUP_DB_M1;
                state  <= ST_SETUP;
              end
              OP_UPDATE: begin
                curSel <= SEL_UPDATE;
                cnt    <= SETUP_DB_M1;
                state  <= ST_SETUP;
              end
              OP_BOTH: begin
                if (cmdTransparent) begin
                  curSel    <= SEL_THROUGH;
                  longPulse <= 1'b1;
                  cnt       <= SETUP_SB_M1;
                end else begin
                  curSel     <= SEL_LOAD;
                  pendUpdate <= 1'b1;
                  cnt        <= SETUP_DB_M1;
                end
                state <= ST_SETUP;
              end
              default: begin
                cnt   <= CLR_M1;
                state <= ST_CLEAR;
              end
            endcase
          end
        end
        ST_SETUP: begin
          if (cntDone) begin
            cnt   <= longPulse ? WP_SB_M1 : WP_M1;
            state <= ST_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cntDone) begin
            cnt   <= HOLD_M1;
            state <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cntDone) begin
            if (pendUpdate) begin
              curSel     <= SEL_UPDATE;
              pendUpdate <= 1'b0;
              cnt        <= SETUP_DB_M1;
              state      <= ST_SETUP;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CLEAR: begin
          if (cntDone) begin
            state <= ST_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmdReady        = (state == ST_IDLE);
    strobe.capture  = accept && (cmdOp_e'(cmdOp) != OP_CLEAR);
    strobe.driveSel = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    strobe.selCode  = curSel;
    strobe.wrLow    = (state == ST_STROBE);
    strobe.clrLow   = (state == ST_CLEAR);
  end

endmodule

// File: rtl/dac_seq_dpath.sv
module dac_seq_dpath
  import dac_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] cmdData,
  output logic [1:0]        dacSel,
  output logic [DATA_W-1:0] dacData,
  output logic              dacWrN,
  output logic              dacClrN
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacData <= '0;
      dacSel  <= SEL_IDLE;
      dacWrN  <= 1'b1;
      dacClrN <= 1'b1;
    end else begin
      if (strobe.capture) dacData <= cmdData;
      dacSel  <= strobe.driveSel ? strobe.selCode : SEL_IDLE;
      dacWrN  <= ~strobe.wrLow;
      dacClrN <= ~strobe.clrLow;
    end
  end

endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq
  import dac_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_SETUP_NS    = 50,
  parameter int T_HOLD_NS     = 10,
  parameter int T_WP_NS       = 50,
  parameter int T_WP_SB_NS    = 80,
  parameter int T_CLR_NS      = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic              cmdTransparent,
  input  logic [DATA_W-1:0] cmdData,
  output logic [1:0]        dacSel,
  output logic [DATA_W-1:0] dacData,
  output logic              dacWrN,
  output logic              dacClrN
);

  localparam int SETUP_CYC = nsToCycles(T_SETUP_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC  = nsToCycles(T_HOLD_NS, CLK_PERIOD_NS);
  localparam int WP_CYC    = nsToCycles(T_WP_NS, CLK_PERIOD_NS);
  localparam int WP_SB_CYC = nsToCycles(T_WP_SB_NS, CLK_PERIOD_NS);
  localparam int CLR_CYC   = nsToCycles(T_CLR_NS, CLK_PERIOD_NS);

  seqStrobe_t strobe;

  dac_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .WP_CYC   (WP_CYC),
    .WP_SB_CYC(WP_SB_CYC),
    .HOLD_CYC (HOLD_CYC),
    .CLR_CYC  (CLR_CYC)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .cmdValid      (cmdValid),
    .cmdOp         (cmdOp),
    .cmdTransparent(cmdTransparent),
    .cmdReady      (cmdReady),
    .strobe        (strobe)
  );

  dac_seq_dpath #(
    .DATA_W(DATA_W)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cmdData(cmdData),
    .dacSel (dacSel),
    .dacData(dacData),
    .dacWrN (dacWrN),
    .dacClrN(dacClrN)
  );

endmodule

// File: rtl/dac_write_seq_chk.sv
module dac_write_seq_chk
  import dac_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WP_NS       = 50,
  parameter int T_WP_SB_NS    = 80,
  parameter int T_CLR_NS      = 200
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        dacSel,
  input logic [DATA_W-1:0] dacData,
  input logic              dacWrN,
  input logic              dacClrN
);

  localparam int WP_CYC    = nsToCycles(T_WP_NS, CLK_PERIOD_NS);
  localparam int WP_SB_CYC = nsToCycles(T_WP_SB_NS, CLK_PERIOD_NS);
  localparam int CLR_CYC   = nsToCycles(T_CLR_NS, CLK_PERIOD_NS);

  logic [15:0] wrLowRun;
  logic [15:0] clrLowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLowRun  <= '0;
      clrLowRun <= '0;
    end else begin
      wrLowRun  <= dacWrN  ? '0 : wrLowRun + 1'b1;
      clrLowRun <= dacClrN ? '0 : clrLowRun + 1'b1;
    end
  end

  p_strobe_not_long_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dacWrN |-> (wrLowRun < 16'(WP_SB_CYC)));

  p_strobe_not_short_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacWrN) |-> (wrLowRun >= 16'(WP_CYC)));

  p_sel_valid_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dacWrN |-> (dacSel != 2'b11));

  p_bus_stable_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!dacWrN && $past(!dacWrN)) |-> ($stable(dacSel) && $stable(dacData)));

  p_sel_at_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacWrN) |-> $stable(dacSel));

  p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dacClrN |-> (dacWrN && (dacSel == 2'b11)));

  p_clear_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacClrN) |-> (clrLowRun == 16'(CLR_CYC)));

  p_busy_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!dacWrN || !dacClrN) |-> !cmdReady);

  p_data_stable_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && $past(!cmdReady)) |-> $stable(dacData));

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !cmdValid) |=> cmdReady);

endmodule

bind dac_write_seq dac_write_seq_chk #(
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_WP_NS      (T_WP_NS),
  .T_WP_SB_NS   (T_WP_SB_NS),
  .T_CLR_NS     (T_CLR_NS)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cmdValid(cmdValid),
  .cmdReady(cmdReady),
  .dacSel  (dacSel),
  .dacData (dacData),
  .dacWrN  (dacWrN),
  .dacClrN (dacClrN)
);

// File: tb/dac_write_seq_tb_top.sv
module dac_write_seq_tb_top;

  localparam int PERIOD = 8;

  function automatic int toCyc(input int ns);
    int c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SETUP_C = toCyc(50);
  localparam int HOLD_C  = toCyc(10);
  localparam int WP_C    = toCyc(50);
  localparam int WPSB_C  = toCyc(80);
  localparam int CLR_C   = toCyc(200);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = 2'd0;
  logic        cmdTransparent = 1'b0;
  logic [15:0] cmdData = '0;
  logic [1:0]  dacSel;
  logic [15:0] dacData;
  logic        dacWrN;
  logic        dacClrN;

  always #(PERIOD / 2) clk = ~clk;

  dac_write_seq #(.CLK_PERIOD_NS(PERIOD)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdTransparent(cmdTransparent), .cmdData(cmdData),
    .dacSel(dacSel), .dacData(dacData), .dacWrN(dacWrN), .dacClrN(dacClrN)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // waveform monitor, independent of the design's state
  int          nWr = 0, nClr = 0, clrBad = 0;
  int          wrSelLog [64];
  int          wrDataLog[64];
  int          wrWidth  [64];
  int          wrSelAge [64];
  int          wrDataAge[64];
  int          wrHold   [64];
  int          clrWidth [64];
  int          lowCnt = 0, clrCnt = 0, selAge = 0, dataAge = 0;
  int          holdCnt = 0, holdIdx = 0;
  bit          holdOn = 1'b0;
  logic        prevWr = 1'b1, prevClr = 1'b1;
  logic [1:0]  prevSel = 2'b11, holdSel = 2'b11;
  logic [15:0] prevData = '0, holdData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!dacWrN) lowCnt++;
      if (!dacClrN) begin
        clrCnt++;
        if (!dacWrN || dacSel != 2'b11) clrBad++;
      end
      if (dacWrN && !prevWr && nWr < 64) begin
        wrSelLog[nWr]  = int'(dacSel);
        wrDataLog[nWr] = int'(dacData);
        wrWidth[nWr]   = lowCnt;
        wrSelAge[nWr]  = selAge;
        wrDataAge[nWr] = dataAge;
        wrHold[nWr]    = -1;
        holdIdx        = nWr;
        holdOn         = 1'b1;
        holdCnt        = 0;
        holdSel        = dacSel;
        holdData       = dacData;
        nWr++;
        lowCnt = 0;
      end
      if (dacClrN && !prevClr && nClr < 64) begin
        clrWidth[nClr] = clrCnt;
        nClr++;
        clrCnt = 0;
      end
      if (holdOn) begin
        if (dacSel != holdSel || dacData != holdData) begin
          wrHold[holdIdx] = holdCnt;
          holdOn = 1'b0;
        end else begin
          holdCnt++;
        end
      end
      selAge  = (dacSel == prevSel) ? selAge + 1 : 1;
      dataAge = (dacData == prevData) ? dataAge + 1 : 1;
    end
    prevWr   = dacWrN;
    prevClr  = dacClrN;
    prevSel  = dacSel;
    prevData = dacData;
  end

  typedef struct packed {
    logic [1:0]  op;
    logic        tr;
    logic [15:0] data;
    logic [1:0]  expWr;
    logic [1:0]  sel0;
    logic [1:0]  sel1;
    logic [7:0]  width;
    logic        expClr;
    logic [15:0] bus;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 16'hA5A5, 2'd1, 2'b10, 2'b10, 8'(WP_C),   1'b0, 16'hA5A5, 8'd2},
    '{2'd1, 1'b0, 16'h1234, 2'd1, 2'b01, 2'b01, 8'(WP_C),   1'b0, 16'h1234, 8'd3},
    '{2'd2, 1'b0, 16'hFFFF, 2'd2, 2'b10, 2'b01, 8'(WP_C),   1'b0, 16'hFFFF, 8'd4},
    '{2'd2, 1'b1, 16'h0000, 2'd1, 2'b00, 2'b00, 8'(WPSB_C), 1'b0, 16'h0000, 8'd5},
    '{2'd3, 1'b0, 16'hBEEF, 2'd0, 2'b11, 2'b11, 8'(WP_C),   1'b1, 16'h0000, 8'd9},
    '{2'd0, 1'b1, 16'h8000, 2'd1, 2'b10, 2'b10, 8'(WP_C),   1'b0, 16'h8000, 8'd10},
    '{2'd1, 1'b1, 16'h7FFF, 2'd1, 2'b01, 2'b01, 8'(WP_C),   1'b0, 16'h7FFF, 8'd10},
    '{2'd3, 1'b1, 16'h0001, 2'd0, 2'b11, 2'b11, 8'(WP_C),   1'b1, 16'h7FFF, 8'd10},
    '{2'd2, 1'b0, 16'h0001, 2'd2, 2'b10, 2'b01, 8'(WP_C),   1'b0, 16'h0001, 8'd4}
  };

  task automatic waitReady();
    do @(negedge clk); while (!cmdReady);
  endtask

  task automatic checkWrite(input int idx, input int expSel, input int expData,
                            input int expWidth, input string req);
    chk(wrSelLog[idx] == expSel, req, "select code", wrSelLog[idx], expSel);
    chk(wrDataLog[idx] == expData, req, "data at strobe", wrDataLog[idx], expData);
    chk(wrWidth[idx] == expWidth, "R6/R5", "strobe low cycles", wrWidth[idx], expWidth);
    chk(wrSelAge[idx] >= SETUP_C, "R7", "select setup cycles", wrSelAge[idx], SETUP_C);
    chk(wrDataAge[idx] >= SETUP_C, "R7", "data setup cycles", wrDataAge[idx], SETUP_C);
    chk(wrHold[idx] >= HOLD_C, "R8", "hold cycles", wrHold[idx], HOLD_C);
  endtask

  task automatic checkIdle(input string req);
    chk(dacSel == 2'b11, req, "idle select", int'(dacSel), 3);
    chk(dacWrN == 1'b1 && dacClrN == 1'b1, req, "idle strobes",
        int'({dacWrN, dacClrN}), 3);
  endtask

  initial begin
    #(200000 * PERIOD);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    checkIdle("R1");
    chk(dacData == 16'h0 && cmdReady, "R1", "reset data/ready",
        int'({cmdReady, dacData}), 32'h10000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1");
    chk(cmdReady == 1'b1, "R1", "ready after reset", int'(cmdReady), 1);

    for (int v = 0; v < NV; v++) begin
      int baseW, baseC, badC;
      string req;
      req = $sformatf("R%0d", VECS[v].tag);
      baseW = nWr; baseC = nClr; badC = clrBad;
      cmdOp = VECS[v].op; cmdTransparent = VECS[v].tr; cmdData = VECS[v].data;
      cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
      chk(cmdReady == 1'b0, "R10", "ready drops after accept", int'(cmdReady), 0);
      waitReady();
      repeat (2) @(negedge clk);
      chk(nWr - baseW == int'(VECS[v].expWr), req, "write count", nWr - baseW,
          int'(VECS[v].expWr));
      chk(nClr - baseC == int'(VECS[v].expClr), req, "clear count", nClr - baseC,
          int'(VECS[v].expClr));
      if (VECS[v].expWr >= 2'd1 && nWr - baseW >= 1)
        checkWrite(baseW, int'(VECS[v].sel0), int'(VECS[v].data), int'(VECS[v].width), req);
      if (VECS[v].expWr == 2'd2 && nWr - baseW >= 2)
        checkWrite(baseW + 1, int'(VECS[v].sel1), int'(VECS[v].data), int'(VECS[v].width), "R4");
      if (VECS[v].expClr && nClr - baseC >= 1) begin
        chk(clrWidth[baseC] == CLR_C, "R9", "clear low cycles", clrWidth[baseC], CLR_C);
        chk(clrBad == badC, "R9", "strobe or select active in clear", clrBad - badC, 0);
      end
      chk(dacData == VECS[v].bus, req, "bus data after command", int'(dacData),
          int'(VECS[v].bus));
      checkIdle("R11");
    end

    // back-to-back: second command held on valid throughout the first one
    begin
      int baseW;
      bit moved;
      moved = 1'b0;
      baseW = nWr;
      cmdOp = 2'd0; cmdTransparent = 1'b0; cmdData = 16'h1111; cmdValid = 1'b1;
      @(negedge clk);
      cmdOp = 2'd1; cmdData = 16'h2222;
      while (!cmdReady) begin
        if (dacData != 16'h1111) moved = 1'b1;
        @(negedge clk);
      end
      @(negedge clk);
      cmdValid = 1'b0;
      chk(!moved, "R10", "bus changed while busy", int'(moved), 0);
      waitReady();
      repeat (2) @(negedge clk);
      chk(nWr - baseW == 2, "R10", "back-to-back write count", nWr - baseW, 2);
      if (nWr - baseW >= 2) begin
        checkWrite(baseW, 2, 16'h1111, WP_C, "R2");
        checkWrite(baseW + 1, 1, 16'h2222, WP_C, "R3");
      end
      checkIdle("R11");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule